// File: doc/BRIEF.md
# Vector Length Prefix Decode Unit

This unit takes the 12-bit length-control field carried by an instruction prefix and turns it into updates of two architectural values: the maximum vector length (the cap) and the current vector length. Bits 10:6 are a 5-bit immediate that always becomes the new cap. The current length becomes either the cap itself or the smaller of an integer register value and the cap. The new length can also be written back to an integer register.

Bit 11 picks one of two layouts for the register operands. When it is clear, the field holds two 3-bit compressed specifiers, one for the destination and one for the source. When it is set, the field holds one full 5-bit specifier plus a mode bit that says whether it names a destination or a source. The source register is read through a combinational read port in the same cycle as the valid strobe. Any state change, write-back or illegal indication appears after the next rising clock edge.

Top module: `vlen_prefix_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the cap and the length both equal RESET_LEN, wb_en is 0 and illegal is 0.
- R2: A valid field that is all zero leaves the cap and the length unchanged, writes no register and does not raise illegal.
- R3: When fld_valid is low, the field is ignored: the cap and the length keep their values, and wb_en and illegal are 0 after the next edge.
- R4: With bit 11 clear, bits 2:0 are a compressed source n. When n is nonzero, rd_raddr equals CREG_BASE+n (default 8+n) in the valid cycle, and the length becomes min(register, immediate). The cap becomes the immediate (bits 10:6).
- R5: With bit 11 clear, bits 5:3 are a compressed destination m. When m is nonzero, the new length is written to register CREG_BASE+m. When the source is absent, the length becomes the immediate.
- R6: With bit 11 clear, both specifiers zero and a nonzero immediate, the cap and the length both become the immediate and nothing is written.
- R7: With bit 11 set and bit 5 clear, bits 4:0 are a full destination. The cap and the length become the immediate, and the length is written to that register when it is nonzero.
- R8: With bit 11 set, bit 5 set and bits 4:0 nonzero, bits 4:0 name a full source. rd_raddr equals that index, the cap becomes the immediate and the length becomes min(register, immediate). Nothing is written.
- R9: With bit 11 set, bit 5 set and bits 4:0 zero, the encoding is reserved. illegal is 1 for exactly the one cycle after the edge, and the cap and the length are unchanged. Nothing is written.
- R10: The minimum is taken over all XLEN bits as an unsigned value. A register value with any bit set above the length width saturates to the cap, so the length never exceeds the cap.
- R11: Updates and write-backs appear one clock edge after the valid cycle. wb_en is a one-cycle pulse with wb_data equal to the new length, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fld_valid | input | 1 | Field strobe |
| fld | input | 12 | Length-control field |
| rd_rdata | input | XLEN | Read data from the register file |
| rd_raddr | output | 5 | Register read index (0 when no source is used) |
| mvl_q | output | LEN_W | Current cap (maximum vector length) |
| vl_q | output | LEN_W | Current vector length |
| wb_en | output | 1 | Write-back enable |
| wb_addr | output | 5 | Write-back register index |
| wb_data | output | XLEN | Write-back data |
| illegal | output | 1 | Reserved-encoding indication |

## Verification
A wrong layout decode shows up in the same cycle as the strobe, because rd_raddr points at the wrong register. It also shows one edge later as a wrong length or a missing or stray write-back pulse. Register values with bits set above the length width expose a minimum that looks only at the low bits: the length then falls below the cap when it should saturate. Both the reserved encoding and the all-zero field must leave the cap and the length frozen on the cycle right after the edge, so a faulty hold path shows at once.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
   localparam int FIELD_W = 12;
   localparam int IMM_W   = 5;
   localparam int RIDX_W  = 5;
   localparam int CIDX_W  = 3;

   typedef enum logic [1:0] {
      VLP_HOLD = 2'd0,
      VLP_SET  = 2'd1,
      VLP_RESV = 2'd2
   } vlp_kind_e;

   typedef struct packed {
      vlp_kind_e         kind;
      logic              use_src;
      logic              do_wb;
      logic [RIDX_W-1:0] src;
      logic [RIDX_W-1:0] dst;
      logic [IMM_W-1:0]  imm;
   } vlp_dec_t;
endpackage

// File: rtl/vlp_field_decode.sv
module vlp_field_decode
   import vlp_pkg::*;
#(
   parameter int CREG_BASE = 8
) (
   input  logic [FIELD_W-1:0] fld,
   output vlp_dec_t           dec
);
   localparam int CREG_TOP = CREG_BASE + (1 << CIDX_W) - 1;

   if (CREG_TOP >= (1 << RIDX_W)) begin : g_bad_base
      $error("CREG_BASE puts compressed registers outside the register file");
   end

   logic [CIDX_W-1:0] c_dst, c_src;
   logic [RIDX_W-1:0] f_idx;
   logic              layout_full, full_is_src;

   assign layout_full = fld[11];
   assign full_is_src = fld[5];
   assign c_dst       = fld[5:3];
   assign c_src       = fld[2:0];
   assign f_idx       = fld[4:0];

   function automatic logic [RIDX_W-1:0] expand_c(input logic [CIDX_W-1:0] n);
      return RIDX_W'(CREG_BASE) + RIDX_W'(n);
   endfunction

   always_comb begin
      dec         = '0;
      dec.imm     = fld[10:6];
      dec.kind    = VLP_SET;
      if (fld == '0) begin
         dec.kind = VLP_HOLD;
      end else if (!layout_full) begin
         dec.use_src = (c_src != '0);
         dec.src     = (c_src != '0) ? expand_c(c_src) : '0;
         dec.do_wb   = (c_dst != '0);
         dec.dst     = (c_dst != '0) ? expand_c(c_dst) : '0;
      end else if (full_is_src) begin
         if (f_idx == '0) begin
            dec.kind = VLP_RESV;
         end else begin
            dec.use_src = 1'b1;
            dec.src     = f_idx;
         end
      end else begin
         dec.do_wb = (f_idx != '0);
         dec.dst   = f_idx;
      end
   end
endmodule

// File: rtl/vlp_len_calc.sv
module vlp_len_calc
   import vlp_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int LEN_W = 6
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             use_src,
   input  logic [XLEN-1:0]  src_val,
   output logic [LEN_W-1:0] mvl_new,
   output logic [LEN_W-1:0] vl_new
);
   if (LEN_W < IMM_W) begin : g_bad_len
      $error("LEN_W must hold the immediate");
   end
   if (XLEN < LEN_W) begin : g_bad_xlen
      $error("XLEN must be at least LEN_W");
   end

   logic src_below;

   assign mvl_new = LEN_W'(imm);

   if (XLEN > LEN_W) begin : g_wide
      logic hi_set;
      assign hi_set    = |src_val[XLEN-1:LEN_W];
      assign src_below = !hi_set && (src_val[LEN_W-1:0] < mvl_new);
   end else begin : g_narrow
      assign src_below = (src_val[LEN_W-1:0] < mvl_new);
   end

   assign vl_new = (use_src && src_below) ? src_val[LEN_W-1:0] : mvl_new;
endmodule

// File: rtl/vlp_state.sv
module vlp_state
   import vlp_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int LEN_W     = 6,
   parameter int RESET_LEN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  vlp_dec_t          dec,
   input  logic [LEN_W-1:0]  mvl_new,
   input  logic [LEN_W-1:0]  vl_new,
   output logic [LEN_W-1:0]  mvl_q,
   output logic [LEN_W-1:0]  vl_q,
   output logic              wb_en,
   output logic [RIDX_W-1:0] wb_addr,
   output logic [XLEN-1:0]   wb_data,
   output logic              illegal
);
   if (RESET_LEN >= (1 << LEN_W)) begin : g_bad_rst
      $error("RESET_LEN does not fit in LEN_W");
   end

   logic take;
   assign take = valid && (dec.kind == VLP_SET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mvl_q   <= LEN_W'(RESET_LEN);
         vl_q    <= LEN_W'(RESET_LEN);
         wb_en   <= 1'b0;
         wb_addr <= '0;
         wb_data <= '0;
         illegal <= 1'b0;
      end else begin
         wb_en   <= take && dec.do_wb;
         illegal <= valid && (dec.kind == VLP_RESV);
         if (take) begin
            mvl_q <= mvl_new;
            vl_q  <= vl_new;
         end
         if (take && dec.do_wb) begin
            wb_addr <= dec.dst;
            wb_data <= XLEN'(vl_new);
         end
      end
   end

   p_vl_within_mvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= mvl_q);

   p_resv_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && dec.kind == VLP_RESV) |=>
         ($stable(mvl_q) && $stable(vl_q) && !wb_en && illegal));

   p_zero_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && dec.kind == VLP_HOLD) |=>
         ($stable(mvl_q) && $stable(vl_q) && !wb_en && !illegal));

   p_idle_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> ($stable(mvl_q) && $stable(vl_q) && !wb_en && !illegal));

   p_wb_matches_vl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data == XLEN'(vl_q)));
endmodule

// File: rtl/vlen_prefix_unit.sv
module vlen_prefix_unit
   import vlp_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int LEN_W     = 6,
   parameter int RESET_LEN = 1,
   parameter int CREG_BASE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fld_valid,
   input  logic [11:0]      fld,
   input  logic [XLEN-1:0]  rd_rdata,
   output logic [4:0]       rd_raddr,
   output logic [LEN_W-1:0] mvl_q,
   output logic [LEN_W-1:0] vl_q,
   output logic             wb_en,
   output logic [4:0]       wb_addr,
   output logic [XLEN-1:0]  wb_data,
   output logic             illegal
);
   vlp_dec_t         dec;
   logic [LEN_W-1:0] mvl_new, vl_new;

   vlp_field_decode #(.CREG_BASE(CREG_BASE)) u_dec (
      .fld (fld),
      .dec (dec)
   );

   assign rd_raddr = (fld_valid && dec.use_src) ? dec.src : '0;

   vlp_len_calc #(.XLEN(XLEN), .LEN_W(LEN_W)) u_calc (
      .imm     (dec.imm),
      .use_src (dec.use_src),
      .src_val (rd_rdata),
      .mvl_new (mvl_new),
      .vl_new  (vl_new)
   );

   vlp_state #(.XLEN(XLEN), .LEN_W(LEN_W), .RESET_LEN(RESET_LEN)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (fld_valid),
      .dec     (dec),
      .mvl_new (mvl_new),
      .vl_new  (vl_new),
      .mvl_q   (mvl_q),
      .vl_q    (vl_q),
      .wb_en   (wb_en),
      .wb_addr (wb_addr),
      .wb_data (wb_data),
      .illegal (illegal)
   );

   p_craddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_valid && !fld[11] && fld[2:0] != 3'd0) |->
         (rd_raddr == 5'(CREG_BASE) + 5'(fld[2:0])));

   p_fraddr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_valid && fld[11] && fld[5] && fld[4:0] != 5'd0) |->
         (rd_raddr == fld[4:0]));

   p_cap_from_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_valid && fld != 12'd0 && !(fld[11] && fld[5] && fld[4:0] == 5'd0)) |=>
         (mvl_q == LEN_W'($past(fld[10:6]))));
endmodule

// File: tb/sim_vlen_prefix_unit.sv
module sim_vlen_prefix_unit;
   localparam int XLEN = 64;
   localparam int LW   = 6;
   localparam int RLEN = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fld_valid = 1'b0;
   logic [11:0]     fld = '0;
   logic [XLEN-1:0] rd_rdata;
   logic [4:0]      rd_raddr;
   logic [LW-1:0]   mvl_q, vl_q;
   logic            wb_en, illegal;
   logic [4:0]      wb_addr;
   logic [XLEN-1:0] wb_data;

   logic [XLEN-1:0] rf [32];
   int total = 0, bad = 0;
   bit finished = 0;
   logic [LW-1:0] e_mvl = LW'(RLEN), e_vl = LW'(RLEN);

   always #4 clk = ~clk;
   assign rd_rdata = rf[rd_raddr];

   vlen_prefix_unit #(.XLEN(XLEN), .LEN_W(LW), .RESET_LEN(RLEN), .CREG_BASE(8)) u0 (
      .clk(clk), .rst_n(rst_n), .fld_valid(fld_valid), .fld(fld), .rd_rdata(rd_rdata),
      .rd_raddr(rd_raddr), .mvl_q(mvl_q), .vl_q(vl_q), .wb_en(wb_en),
      .wb_addr(wb_addr), .wb_data(wb_data), .illegal(illegal));

   task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                      input logic [XLEN-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [11:0] f, input bit v, input string req);
      bit hold, resv, s_use, d_use;
      logic [4:0] s_idx, d_idx;
      logic [LW-1:0] imm, nvl;
      hold = (f == 12'd0); resv = 0; s_use = 0; d_use = 0; s_idx = 0; d_idx = 0;
      imm = LW'(f[10:6]);
      if (!hold) begin
         if (!f[11]) begin
            s_use = (f[2:0] != 0); s_idx = 5'd8 + 5'(f[2:0]);
            d_use = (f[5:3] != 0); d_idx = 5'd8 + 5'(f[5:3]);
         end else if (f[5]) begin
            resv = (f[4:0] == 0); s_use = !resv; s_idx = f[4:0];
         end else begin
            d_use = (f[4:0] != 0); d_idx = f[4:0];
         end
      end
      @(negedge clk);
      fld = f; fld_valid = v;
      #1;
      chk(rd_raddr == ((v && s_use) ? s_idx : 5'd0), req, rd_raddr,
          (v && s_use) ? s_idx : 5'd0);
      nvl = imm;
      if (s_use && rf[s_idx] < XLEN'(imm)) nvl = rf[s_idx][LW-1:0];
      @(posedge clk); #1;
      if (v && !hold && !resv) begin
         e_mvl = imm; e_vl = nvl;
      end
      chk(mvl_q == e_mvl, req, mvl_q, e_mvl);
      chk(vl_q == e_vl, req, vl_q, e_vl);
      chk(wb_en == (v && !hold && !resv && d_use), req, wb_en, v && !hold && !resv && d_use);
      if (wb_en && v && d_use) begin
         chk(wb_addr == d_idx, req, wb_addr, d_idx);
         chk(wb_data == XLEN'(e_vl), req, wb_data, XLEN'(e_vl));
      end
      chk(illegal == (v && resv), req, illegal, v && resv);
   endtask

   initial begin
      #1600000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=1 exp=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 32; i++)
         rf[i] = (i % 3 == 0) ? {$urandom, $urandom} : XLEN'($urandom % 40);
      rf[9]  = 64'h1_0000_0003;
      rf[10] = 64'd5;
      rf[17] = 64'd20;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values
      chk(mvl_q == LW'(RLEN) && vl_q == LW'(RLEN), "R1", {mvl_q, vl_q}, {6'(RLEN), 6'(RLEN)});
      chk(!wb_en && !illegal, "R1", {wb_en, illegal}, 0);
      @(negedge clk); rst_n = 1'b1;
      apply(12'd0, 1, "R1");
      apply({1'b1, 5'd12, 1'b0, 5'd0}, 1, "R7");           // cap=len=12, no write
      apply(12'd0, 1, "R2");                                // frozen
      apply({1'b1, 5'd25, 1'b1, 5'd17}, 0, "R3");           // strobe low ignored
      apply({1'b0, 5'd20, 3'd0, 3'd2}, 1, "R4");            // min(5,20)=5
      apply({1'b0, 5'd20, 3'd0, 3'd1}, 1, "R10");           // upper bits -> saturate 20
      apply({1'b0, 5'd9, 3'd3, 3'd0}, 1, "R5");             // write 9 to r11
      apply({1'b0, 5'd7, 3'd4, 3'd2}, 1, "R5");             // min(5,7)=5 to r12
      apply({1'b0, 5'd14, 3'd0, 3'd0}, 1, "R6");
      apply({1'b1, 5'd30, 1'b0, 5'd3}, 1, "R7");
      apply({1'b1, 5'd18, 1'b1, 5'd0}, 1, "R9");            // reserved
      apply({1'b1, 5'd31, 1'b1, 5'd17}, 1, "R8");           // min(20,31)=20
      apply({1'b1, 5'd20, 1'b1, 5'd17}, 1, "R10");          // equal -> 20
      apply({1'b1, 5'd4, 1'b0, 5'd6}, 1, "R11");
      apply({1'b1, 5'd4, 1'b0, 5'd6}, 0, "R11");            // pulse ends
      for (int k = 0; k < 600; k++) begin
         logic [11:0] rf_f;
         rf_f = 12'($urandom);
         if (k % 11 == 0) rf_f[5:0] = 6'b100000;
         apply(rf_f, ($urandom % 8) != 0, "R4");
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule